// File: doc/BRIEF.md
# 64-bit Global Timer with Comparator

This peripheral keeps a free-running 64-bit up-counter and a 64-bit compare value, both reached through a 32-bit register bus. Software can read the counter as two 32-bit words and can set it while the timer is stopped. When comparison is enabled and the count reaches the compare value, the block records an event in a sticky status flag. If the interrupt enable is on, it also drives a single-cycle interrupt pulse.

In auto-increment mode, every event adds a programmable 32-bit step to the compare value, so the block produces periodic ticks with no drift and no software help. Software changes the compare value only while comparison is disabled. It writes both halves and then enables comparison again. To acknowledge an event, software writes one to the status register.

Register word offsets: 0 counter low, 1 counter high, 2 control, 3 status, 4 compare low, 5 compare high, 6 increment step. Offset 7 is unmapped. Control bits: bit 0 run, bit 1 compare enable, bit 2 interrupt enable, bit 3 auto-increment.

Top module: `wide_tick_timer`

## Requirements
- R1: After reset the counter, compare value, step, control and status all read zero, and `irq` is low.
- R2: The counter adds one on every clock while control bit 0 (run) is set, and holds its value while run is clear.
- R3: A write to offset 0 or offset 1 replaces that half of the counter only while run is clear. Such writes are ignored while run is set.
- R4: A read strobe returns the addressed register on `bus_rdata` one cycle later. The counter words give the live 64-bit value at that strobe, including a carry from the low word into the high word.
- R5: While control bit 1 (compare enable) is set, the count becoming greater than or equal to the compare value is one event and sets status bit 0. A condition that stays true with no reload produces no further events.
- R6: `irq` is high for exactly one cycle, in the cycle after each event, and only if control bit 2 (interrupt enable) is set. `irq` is never high while status bit 0 is clear.
- R7: With control bit 3 (auto-increment) set, each event adds the 32-bit step at offset 6 to the 64-bit compare value. Events then repeat every step counts.
- R8: Writing a value with bit 0 set to offset 3 clears status bit 0. If an event falls in the same cycle as that write, the flag stays set.
- R9: Writes to offset 7 change nothing, and reads of offset 7 return zero.
- R10: The control register reads back the four bits as written, at the bit positions given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read strobe |
| irq | output | 1 | One-cycle event pulse |

## Verification
A new compare event and the software acknowledge can land in the same cycle. The bench provokes this with the timer stopped and comparison enabled. It loads the counter up to the compare value, which arms the event in the following cycle, and writes the acknowledge to the status register in exactly that cycle. It then judges the outcome by reading status, which must still show the flag, and by counting exactly one interrupt pulse. A second acknowledge with no event pending must then clear the flag.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned WIDE_W = 2 * WORD_W;

  typedef enum logic [2:0] {
    OFS_CNT_LO = 3'd0,
    OFS_CNT_HI = 3'd1,
    OFS_CTRL   = 3'd2,
    OFS_STAT   = 3'd3,
    OFS_CMP_LO = 3'd4,
    OFS_CMP_HI = 3'd5,
    OFS_STEP   = 3'd6
  } ofs_e;

  // bit 0 run, bit 1 compare enable, bit 2 irq enable, bit 3 auto-increment
  typedef struct packed {
    logic auto_inc;
    logic irq_en;
    logic cmp_en;
    logic run;
  } ctrl_t;

  // replace one 32-bit half of a 64-bit value
  function automatic logic [WIDE_W-1:0] put_half(input logic [WIDE_W-1:0] v,
                                                 input logic upper,
                                                 input logic [WORD_W-1:0] d);
    logic [WIDE_W-1:0] r;
    r = v;
    if (upper) r[WIDE_W-1:WORD_W] = d;
    else       r[WORD_W-1:0] = d;
    return r;
  endfunction

  // compare reload: old value plus zero-extended step
  function automatic logic [WIDE_W-1:0] advance_cmp(input logic [WIDE_W-1:0] cmp,
                                                    input logic [WORD_W-1:0] step);
    return cmp + {{(WIDE_W-WORD_W){1'b0}}, step};
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
  import gtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  output logic [WIDE_W-1:0] count
);
  logic load_ok;
  assign load_ok = !run && (wr_lo || wr_hi);

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (run)     count <= count + 1'b1;
    else if (load_ok) count <= put_half(count, wr_hi, wdata);
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> count == $past(count) + 1'b1);
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_lo && !wr_hi) |=> $stable(count));
  assert_load_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && wr_lo) |=> count[WORD_W-1:0] == $past(wdata));
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare
  import gtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDE_W-1:0] count,
  input  logic              cmp_en,
  input  logic              auto_en,
  input  logic              irq_en,
  input  logic [WORD_W-1:0] step,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  input  logic              ack,
  output logic [WIDE_W-1:0] cmp,
  output logic              flag,
  output logic              hit,
  output logic              irq
);
  logic armed, armed_q, reload_q, reload;

  assign armed  = cmp_en && (count >= cmp);
  // new event on a rising condition, or again right after a reload
  assign hit    = armed && (!armed_q || reload_q);
  assign reload = hit && auto_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp      <= '0;
      armed_q  <= 1'b0;
      reload_q <= 1'b0;
      flag     <= 1'b0;
      irq      <= 1'b0;
    end else begin
      armed_q  <= armed;
      reload_q <= reload;
      irq      <= hit && irq_en;
      if (hit)      flag <= 1'b1;
      else if (ack) flag <= 1'b0;
      if (wr_lo || wr_hi) cmp <= put_half(cmp, wr_hi, wdata);
      else if (reload)    cmp <= advance_cmp(cmp, step);
    end
  end

  assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
  assert_reload_adds_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && auto_en && !wr_lo && !wr_hi) |=> cmp == $past(cmp) + {32'b0, $past(step)});
  assert_event_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !hit) |=> !flag);
endmodule

// File: rtl/wide_tick_timer.sv
module wide_tick_timer
  import gtmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic wr_en, rd_en;
  logic wr_cnt_lo, wr_cnt_hi, wr_ctrl, wr_stat, wr_cmp_lo, wr_cmp_hi, wr_step;
  ctrl_t ctrl;
  logic [WORD_W-1:0] step;
  logic [WIDE_W-1:0] count, cmp;
  logic flag, hit;
  logic [DATA_W-1:0] rd_mux;

  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;

  assign wr_cnt_lo = wr_en && (bus_addr == ADDR_W'(OFS_CNT_LO));
  assign wr_cnt_hi = wr_en && (bus_addr == ADDR_W'(OFS_CNT_HI));
  assign wr_ctrl   = wr_en && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_stat   = wr_en && (bus_addr == ADDR_W'(OFS_STAT)) && bus_wdata[0];
  assign wr_cmp_lo = wr_en && (bus_addr == ADDR_W'(OFS_CMP_LO));
  assign wr_cmp_hi = wr_en && (bus_addr == ADDR_W'(OFS_CMP_HI));
  assign wr_step   = wr_en && (bus_addr == ADDR_W'(OFS_STEP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      step <= '0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[3:0]);
      if (wr_step) step <= bus_wdata[WORD_W-1:0];
    end
  end

  tmr_counter u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ctrl.run),
    .wr_lo (wr_cnt_lo),
    .wr_hi (wr_cnt_hi),
    .wdata (bus_wdata[WORD_W-1:0]),
    .count (count)
  );

  tmr_compare u_compare (
    .clk     (clk),
    .rst_n   (rst_n),
    .count   (count),
    .cmp_en  (ctrl.cmp_en),
    .auto_en (ctrl.auto_inc),
    .irq_en  (ctrl.irq_en),
    .step    (step),
    .wr_lo   (wr_cmp_lo),
    .wr_hi   (wr_cmp_hi),
    .wdata   (bus_wdata[WORD_W-1:0]),
    .ack     (wr_stat),
    .cmp     (cmp),
    .flag    (flag),
    .hit     (hit),
    .irq     (irq)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFS_CNT_LO): rd_mux = DATA_W'(count[WORD_W-1:0]);
      ADDR_W'(OFS_CNT_HI): rd_mux = DATA_W'(count[WIDE_W-1:WORD_W]);
      ADDR_W'(OFS_CTRL):   rd_mux = DATA_W'(ctrl);
      ADDR_W'(OFS_STAT):   rd_mux = DATA_W'(flag);
      ADDR_W'(OFS_CMP_LO): rd_mux = DATA_W'(cmp[WORD_W-1:0]);
      ADDR_W'(OFS_CMP_HI): rd_mux = DATA_W'(cmp[WIDE_W-1:WORD_W]);
      ADDR_W'(OFS_STEP):   rd_mux = DATA_W'(step);
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
    else            bus_rdata <= '0;
  end

  assert_read_hi_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == ADDR_W'(OFS_CNT_HI)) |=> bus_rdata == DATA_W'($past(count[WIDE_W-1:WORD_W])));
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == ADDR_W'(7)) |=> bus_rdata == '0);
  assert_ctrl_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl == ctrl_t'($past(bus_wdata[3:0])));
endmodule

// File: tb/test_wide_tick_timer.sv
module test_wide_tick_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  int checks = 0, errors = 0, irq_cnt = 0, base;
  logic rd_seen = 1'b0;
  logic done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  wide_tick_timer i_wide_tick_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  always @(posedge clk) rd_seen <= sel && !wr;
  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  // monitor: pops the expected read data and compares
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic check(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic bwr(input logic [2:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic brd(input logic [2:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq after reset", int'(irq), 0);
    brd(3'd0, 32'h0, "R1 count low");
    brd(3'd2, 32'h0, "R1 control");
    brd(3'd3, 32'h0, "R1 status");
    brd(3'd4, 32'h0, "R1 compare low");
    brd(3'd6, 32'h0, "R1 step");

    // R7 periodic events: cmp 20, step 10, all controls on, stop after 46 counts
    bwr(3'd4, 32'd20);
    bwr(3'd5, 32'd0);
    bwr(3'd6, 32'd10);
    bwr(3'd2, 32'hF);
    brd(3'd2, 32'hF, "R10 control readback");
    repeat (44) @(negedge clk);
    bwr(3'd2, 32'h0);
    check("R6 R7 irq pulses over run", irq_cnt, 3);
    brd(3'd4, 32'd50, "R7 compare advanced by step");
    brd(3'd0, 32'd46, "R2 count after run");
    brd(3'd3, 32'h1, "R5 flag set");
    bwr(3'd3, 32'h1);
    brd(3'd3, 32'h0, "R8 flag cleared");

    // R3 R4 counter load and carry
    bwr(3'd0, 32'hFFFF_FFFE);
    bwr(3'd1, 32'h1);
    bwr(3'd2, 32'h1);
    brd(3'd0, 32'hFFFF_FFFE, "R4 low at start");
    brd(3'd1, 32'h1, "R4 high before carry");
    brd(3'd1, 32'h2, "R4 high after carry");
    brd(3'd0, 32'h1, "R4 low after carry");
    bwr(3'd0, 32'h55);          // ignored while running
    bwr(3'd2, 32'h0);
    brd(3'd0, 32'h4, "R3 write ignored while running");
    brd(3'd1, 32'h2, "R3 high unchanged");
    brd(3'd0, 32'h4, "R2 hold while stopped");

    // R8 event and acknowledge in the same cycle
    bwr(3'd4, 32'h10);
    bwr(3'd5, 32'h2);
    bwr(3'd2, 32'h6);
    base = irq_cnt;
    bwr(3'd0, 32'h10);          // count reaches compare
    bwr(3'd3, 32'h1);           // ack in the event cycle
    repeat (4) @(negedge clk);
    brd(3'd3, 32'h1, "R8 event wins over ack");
    check("R5 R6 single pulse while condition holds", irq_cnt - base, 1);
    bwr(3'd3, 32'h1);
    brd(3'd3, 32'h0, "R5 no retrigger after ack");

    // R6 no irq with interrupt enable clear
    bwr(3'd2, 32'h2);
    bwr(3'd0, 32'h0);
    bwr(3'd0, 32'h10);
    base = irq_cnt;
    repeat (3) @(negedge clk);
    check("R6 no irq when disabled", irq_cnt - base, 0);
    brd(3'd3, 32'h1, "R5 flag without irq");

    // R9 unmapped offset
    bwr(3'd7, 32'hFFFF_FFFF);
    brd(3'd7, 32'h0, "R9 unmapped read");
    brd(3'd2, 32'h2, "R9 control untouched");
    brd(3'd4, 32'h10, "R9 compare untouched");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule